// File: doc/BRIEF.md
# Programmable SD Card Clock Generator

This block derives the SD card clock from the base clock that drives it. Software controls it through one 16-bit control word. The word holds:

- an internal clock enable;
- a read-only flag that reports when the internal clock has settled;
- a card clock enable;
- a divider field.

The card clock runs at the base frequency divided by twice the divider value. A divider of zero passes the base clock straight through. A settling counter stands in for real oscillator lock.

To change frequency, software follows a fixed sequence. It writes zero to stop the card clock. It writes the new divider with the internal enable set. It polls the settled flag. Then it sets the card clock enable. A read-only capability word reports the base frequency in MHz. A value of zero there means the frequency is unknown and must not be used to compute a divider.

The divider encoding depends on the controller version, which is set by a parameter:

- **Newer encoding:** a 10-bit divider. Bits 15:8 of the control word hold divider bits 7:0, and bits 7:6 hold divider bits 9:8.
- **Older encoding:** an 8-bit field in bits 15:8 that only takes powers of two. A written value that is not a power of two is reduced to its highest set bit.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, the control word reads 0x0000 and `sd_clk_o` is low.
- R2: The control word reads back as follows:
  - bit 0 is the stored internal enable;
  - bit 2 is the stored card enable;
  - bit 1 is the settled flag;
  - bits 15:8 are divider bits 7:0;
  - with NEW_ENC=1, bits 7:6 are divider bits 9:8;
  - bits 5:3 always read zero.
- R3: The settled flag (bit 1) rises exactly SETTLE_CYCLES rising edges after the write edge that sets the internal enable. It is never set while bit 0 is clear.
- R4: The settled flag clears at the edge of any write that clears bit 0 or changes the divider. A write that keeps bit 0 set and the divider unchanged does not restart settling.
- R5: `sd_clk_o` stays low unless the settled flag and card enable (bit 2) are both set.
- R6: With a divider N > 0 and the clock running, `sd_clk_o` is high for exactly N base cycles and then low for exactly N base cycles, repeating.
- R7: With a divider of 0 and the clock running, `sd_clk_o` follows the base clock: high while `clk_i` is high and low while it is low.
- R8: With NEW_ENC=0:
  - a written 8-bit divider is stored and used as its highest set bit (0 stays 0);
  - bits 7:6 of a write are ignored and read as zero.
- R9: `caps_o[15:8]` equals BASE_MHZ and all other bits of `caps_o` are zero.
- R10: Clearing card enable while `sd_clk_o` is high does not cut the high phase short. The output stays high for the full N cycles, then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 16 | Control word read data, including the settled flag |
| caps_o | output | 16 | Capability word, base frequency in MHz at bits 15:8 |
| sd_clk_o | output | 1 | Card clock |

## Verification
The bench builds two instances side by side, both with SETTLE_CYCLES=4 so that settling waits are short:

- One instance uses NEW_ENC=1 and BASE_MHZ=48. The bench sweeps small dividers 0 to 6 and the wide values 255, 256, 511 and 1023, which exercises the upper divider bits.
- The other uses NEW_ENC=0 and BASE_MHZ=25. The bench writes all 256 field values to check the highest-bit reduction on readback. It also measures the clock period for every legal power-of-two divider, starting from field values that are not powers of two.

For each divider the bench measures the high and low run lengths at mid-cycle and compares them with N. A divider of zero is checked in both clock phases.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CTL_INT_EN  = 0;
  localparam int CTL_STABLE  = 1;
  localparam int CTL_CARD_EN = 2;
  localparam int DIV_W       = 10;

  // keep only the highest set bit
  function automatic logic [7:0] msb_only(input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (v[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter bit NEW_ENC = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [15:0]      wr_data_i,
  output logic             int_en_o,
  output logic             card_en_o,
  output logic [DIV_W-1:0] div_o,
  output logic             restart_o
);
  logic [DIV_W-1:0] new_div;

  generate
    if (NEW_ENC) begin : g_wide
      assign new_div = {wr_data_i[7:6], wr_data_i[15:8]};
    end else begin : g_pow2
      assign new_div = {2'b00, msb_only(wr_data_i[15:8])};
    end
  endgenerate

  // settling restarts on disable, divider change or enable rise
  assign restart_o = wr_en_i &&
                     (!wr_data_i[CTL_INT_EN] || !int_en_o || (new_div != div_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_o  <= 1'b0;
      card_en_o <= 1'b0;
      div_o     <= '0;
    end else if (wr_en_i) begin
      int_en_o  <= wr_data_i[CTL_INT_EN];
      card_en_o <= wr_data_i[CTL_CARD_EN];
      div_o     <= new_div;
    end
  end
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic int_en_i,
  output logic stable_o
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (int_en_i && !stable_o) begin
      if (cnt_q == LAST) stable_o <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sd_clk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;
  logic             div_q;
  logic             gate_n;
  logic             byp_n;

  assign last = (div_i == '0) ? '0 : div_i - 1'b1;

  // a high phase always completes before the output parks low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!(run_i || div_q)) begin
      cnt_q <= '0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // bypass gate changes only while the base clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_n <= 1'b0;
      byp_n  <= 1'b0;
    end else begin
      gate_n <= run_i;
      byp_n  <= (div_i == '0);
    end
  end

  assign sd_clk_o = byp_n ? (clk_i & gate_n) : div_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter bit       NEW_ENC       = 1'b1,
  parameter bit [7:0] BASE_MHZ      = 8'd50,
  parameter int       SETTLE_CYCLES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic [15:0] caps_o,
  output logic        sd_clk_o
);
  logic             int_en, card_en, stable, restart;
  logic [DIV_W-1:0] div;

  sdclk_ctrl_reg #(.NEW_ENC(NEW_ENC)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .int_en_o(int_en), .card_en_o(card_en), .div_o(div), .restart_o(restart)
  );

  sdclk_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i, .rst_ni, .restart_i(restart), .int_en_i(int_en), .stable_o(stable)
  );

  sdclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(stable & card_en), .div_i(div), .sd_clk_o
  );

  assign rd_data_o = {div[7:0], div[9:8], 3'b000, card_en, stable, int_en};
  assign caps_o    = {BASE_MHZ, 8'h00};
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter bit NEW_ENC = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        sd_clk_o
);
  a_r3_stable_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] |-> rd_data_o[0]);

  a_r3_no_instant_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[1]) |-> $past(rd_data_o[0]));

  a_r4_off_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[0]) |=> !rd_data_o[1]);

  a_r4_div_change_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && (rd_data_o[15:6] != $past(rd_data_o[15:6]))) |-> !rd_data_o[1]);

  a_r5_gated_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_data_o[1] && rd_data_o[2]) && !sd_clk_o) |=> !sd_clk_o);

  a_r8_old_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !NEW_ENC |-> ($onehot0(rd_data_o[15:8]) && rd_data_o[7:6] == 2'b00));
endmodule

bind sdclk_gen sdclk_gen_chk #(.NEW_ENC(NEW_ENC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .sd_clk_o(sd_clk_o)
);

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;
  localparam int SET = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        n_we = 1'b0, o_we = 1'b0;
  logic [15:0] n_wd = '0, o_wd = '0;
  logic [15:0] n_rd, o_rd, n_caps, o_caps;
  logic        n_sd, o_sd;
  int          total = 0, bad = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sdclk_gen #(.NEW_ENC(1'b1), .BASE_MHZ(8'd48), .SETTLE_CYCLES(SET)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(n_we), .wr_data_i(n_wd),
    .rd_data_o(n_rd), .caps_o(n_caps), .sd_clk_o(n_sd));

  sdclk_gen #(.NEW_ENC(1'b0), .BASE_MHZ(8'd25), .SETTLE_CYCLES(SET)) uut_old (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(o_we), .wr_data_i(o_wd),
    .rd_data_o(o_rd), .caps_o(o_caps), .sd_clk_o(o_sd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic sd(input bit old);
    return old ? o_sd : n_sd;
  endfunction

  function automatic logic [15:0] rd(input bit old);
    return old ? o_rd : n_rd;
  endfunction

  // called at a negedge; write lands on the next posedge
  task automatic wr(input bit old, input logic [15:0] d);
    if (old) begin o_we = 1'b1; o_wd = d; end
    else     begin n_we = 1'b1; n_wd = d; end
    @(negedge clk);
    n_we = 1'b0; o_we = 1'b0;
  endtask

  function automatic logic [15:0] enc(input int n);
    logic [9:0] v = 10'(n);
    return {v[7:0], v[9:8], 6'b0};
  endfunction

  // start clock with divider field word f, then measure phases
  task automatic run_and_measure(input bit old, input logic [15:0] f, input int n, input string req);
    int hi = 0, lo = 0, guard = 0;
    wr(old, 16'h0000);
    wr(old, f | 16'h0001);
    repeat (SET) @(negedge clk);
    wr(old, f | 16'h0005);
    if (n == 0) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #5;
        chk({req, " bypass high"}, 32'(sd(old)), 32'd1);
        @(negedge clk); #1;
        chk({req, " bypass low"}, 32'(sd(old)), 32'd0);
      end
    end else begin
      while (sd(old) !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
      while (sd(old) !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
      while (sd(old) === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
      while (sd(old) === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
      chk({req, " high len"}, 32'(hi), 32'(n));
      chk({req, " low len"}, 32'(lo), 32'(n));
    end
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ctrl", 32'(n_rd), 32'h0);
    chk("R1 reset sd_clk", 32'(n_sd), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R9 caps new", 32'(n_caps), 32'h3000);
    chk("R9 caps old", 32'(o_caps), 32'h1900);

    // R2 readback
    wr(0, 16'hFFFF);
    chk("R2 readback", 32'(n_rd), 32'hFFC5);
    wr(0, 16'h0000);

    // R3 settle timing and R5 gating during settle
    wr(0, enc(3) | 16'h0005);
    for (int k = 0; k < SET; k++) begin
      chk("R3 not yet stable", 32'(n_rd[1]), 32'd0);
      chk("R5 low while settling", 32'(n_sd), 32'd0);
      @(negedge clk);
    end
    chk("R3 stable on time", 32'(n_rd[1]), 32'd1);

    // R4 rewrite same value keeps stable
    wr(0, enc(3) | 16'h0001);
    chk("R4 same rewrite keeps stable", 32'(n_rd[1]), 32'd1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R5 low with card off", 32'(n_sd), 32'd0);
    end
    wr(0, enc(4) | 16'h0001);
    chk("R4 divider change drops", 32'(n_rd[1]), 32'd0);
    repeat (SET) @(negedge clk);
    chk("R3 resettled", 32'(n_rd[1]), 32'd1);
    wr(0, enc(4));
    chk("R4 disable drops", 32'(n_rd[1]), 32'd0);

    // R10 stop while high
    begin
      int hi = 0, lo = 0;
      wr(0, enc(3) | 16'h0001);
      repeat (SET) @(negedge clk);
      wr(0, enc(3) | 16'h0005);
      while (n_sd !== 1'b1 && hi < 200) begin @(negedge clk); hi++; end
      hi = 0;
      n_we = 1'b1; n_wd = enc(3) | 16'h0001;
      while (n_sd === 1'b1 && hi < 200) begin
        hi++; @(negedge clk); n_we = 1'b0;
      end
      n_we = 1'b0;
      chk("R10 full high phase", 32'(hi), 32'd3);
      for (int k = 0; k < 30; k++) begin
        if (n_sd === 1'b0) lo++;
        @(negedge clk);
      end
      chk("R10 parked low", 32'(lo), 32'd30);
    end

    // R6/R7 sweep new encoding
    for (int n = 0; n <= 6; n++)
      run_and_measure(0, enc(n), n, n == 0 ? "R7 new" : "R6 new");
    run_and_measure(0, enc(255), 255, "R6 new 255");
    run_and_measure(0, enc(256), 256, "R6 new 256");
    run_and_measure(0, enc(511), 511, "R6 new 511");
    run_and_measure(0, enc(1023), 1023, "R6 new 1023");
    wr(0, 16'h0000);

    // R8 readback sweep, old encoding
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e = 8'h00;
      for (int b = 0; b < 8; b++) if (v[b]) e = 8'(1 << b);
      wr(1, {8'(v), 8'hC0});
      chk("R8 normalized readback", 32'(o_rd), 32'({e, 8'h00}));
    end

    // R8 period with non-pow2 field values
    run_and_measure(1, 16'h0000, 0, "R7 old");
    for (int p = 0; p < 8; p++) begin
      int n = 1 << p;
      run_and_measure(1, {8'((n << 1) - 1), 8'hC0}, n, "R8 old period");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule